// File: doc/BRIEF.md
# Port Pin Edge Interrupt Unit

This block watches a group of general-purpose port pins and raises one maskable interrupt request when any of them makes a chosen transition. Each pin passes through a two-flop synchroniser. An edge is found by comparing the synchronised sample with the sample taken one cycle earlier. A per-pin polarity bit decides whether a rising or a falling transition counts as the active edge. An active edge sets that pin's sticky flag, whatever the pin's enable bit holds. The enable bit only decides whether a set flag reaches the interrupt request.

Software reaches three registers through a simple select/write/read interface: enable, polarity and flags. A write of ones to the flag register clears the matching flags, and zero bits leave their flags alone. The pin value is observed whether the pin is being read as an input or driven as an output elsewhere, so any transition on the wire is seen. A narrower build implements fewer pins than the register width, and the unused upper bits of every register stay at zero.

Top module: `pinirq_top`

## Requirements
- R1: After reset the enable, polarity and flag registers all read 0 and the interrupt output is 0.
- R2: Register select 0 addresses enable, 1 addresses polarity, 2 addresses flags, and 3 reads 0 and ignores writes. Read data is combinational from the select. A write to enable or polarity loads the low bits of the write data at the next clock edge.
- R3: A polarity bit of 1 makes a rising transition active for that pin, and 0 makes a falling transition active. A transition in the other direction leaves the flag unchanged.
- R4: A pin change that is stable before clock edge k shows as a set flag after edge k+2, because of the two synchroniser stages and the sample comparison. The flag sets even when the pin's enable bit is 0.
- R5: Writing to the flag register clears each flag whose write-data bit is 1 and keeps each flag whose bit is 0. A set flag stays set until it is cleared in this way.
- R6: When an active edge and a write-1 clear reach the same flag in the same cycle, the flag ends up 1.
- R7: Changing a polarity bit while the pin is steady sets no flag.
- R8: The interrupt output equals the OR over all pins of flag AND enable, delayed by one clock. A flag whose enable bit is 0 does not raise it.
- R9: With NUM_PINS below the register width, the bits at NUM_PINS and above read 0 in every register and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Raw pin levels, asynchronous to clk |
| regSel | input | 2 | Register select: 0 enable, 1 polarity, 2 flags, 3 none |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | REG_W | Write data |
| rdData | output | REG_W | Read data of the selected register |
| irqOut | output | 1 | Combined registered interrupt request |

## Verification
The bench builds two instances. One has the default eight pins, which fill the register. The other has four pins behind the same eight-bit register interface. The full-width instance carries the edge table, the clear collision, the polarity-toggle case and the exact interrupt latency. The narrow instance makes the unused upper register bits observable, so their read-as-zero and write-ignored behaviour can be checked.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE   = 2'd0,
    SEL_POLARITY = 2'd1,
    SEL_FLAGS    = 2'd2,
    SEL_NONE     = 2'd3
  } regSel_e;

  typedef struct packed {
    logic loadEnable;
    logic loadPolarity;
    logic clearFlags;
  } ctrlStrobe_t;

endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= '0;
    end else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
  import pinirq_pkg::*;
(
  input  logic [1:0]  regSel,
  input  logic        wrEn,
  output ctrlStrobe_t strobe,
  output regSel_e     rdSel
);

  always_comb begin
    rdSel  = regSel_e'(regSel);
    strobe = '0;
    if (wrEn) begin
      unique case (rdSel)
        SEL_ENABLE:   strobe.loadEnable   = 1'b1;
        SEL_POLARITY: strobe.loadPolarity = 1'b1;
        SEL_FLAGS:    strobe.clearFlags   = 1'b1;
        default:      strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/pinirq_datapath.sv
module pinirq_datapath
  import pinirq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int REG_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] syncIn,
  input  ctrlStrobe_t         strobe,
  input  regSel_e             rdSel,
  input  logic [REG_W-1:0]    wrData,
  output logic [REG_W-1:0]    rdData,
  output logic                irqOut,
  output logic [NUM_PINS-1:0] enVec,
  output logic [NUM_PINS-1:0] polVec,
  output logic [NUM_PINS-1:0] flagVec,
  output logic [NUM_PINS-1:0] prevVec
);

  logic [NUM_PINS-1:0] enQ, polQ, flagQ, prevQ, edgeHit;
  logic [NUM_PINS-1:0] wrLow;
  logic                irqQ;

  assign wrLow = wrData[NUM_PINS-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= '0;
      polQ  <= '0;
      prevQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      if (strobe.loadEnable)   enQ  <= wrLow;
      if (strobe.loadPolarity) polQ <= wrLow;
      prevQ <= syncIn;
      irqQ  <= |(flagQ & enQ);
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign edgeHit[g] = polQ[g] ? (syncIn[g] & ~prevQ[g])
                                : (~syncIn[g] & prevQ[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                flagQ[g] <= 1'b0;
      else if (edgeHit[g])                      flagQ[g] <= 1'b1;
      else if (strobe.clearFlags && wrLow[g])   flagQ[g] <= 1'b0;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_ENABLE:   rdData = REG_W'(enQ);
      SEL_POLARITY: rdData = REG_W'(polQ);
      SEL_FLAGS:    rdData = REG_W'(flagQ);
      default:      rdData = '0;
    endcase
  end

  assign irqOut  = irqQ;
  assign enVec   = enQ;
  assign polVec  = polQ;
  assign flagVec = flagQ;
  assign prevVec = prevQ;

endmodule

// File: rtl/pinirq_top.sv
module pinirq_top
  import pinirq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [1:0]          regSel,
  input  logic                wrEn,
  input  logic [REG_W-1:0]    wrData,
  output logic [REG_W-1:0]    rdData,
  output logic                irqOut
);

  ctrlStrobe_t         strobe;
  regSel_e             rdSel;
  logic [NUM_PINS-1:0] syncVec;
  logic [NUM_PINS-1:0] enVec, polVec, flagVec, prevVec;

  pinirq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(syncVec)
  );

  pinirq_ctrl u_ctrl (
    .regSel(regSel), .wrEn(wrEn), .strobe(strobe), .rdSel(rdSel)
  );

  pinirq_datapath #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .syncIn(syncVec), .strobe(strobe),
    .rdSel(rdSel), .wrData(wrData), .rdData(rdData), .irqOut(irqOut),
    .enVec(enVec), .polVec(polVec), .flagVec(flagVec), .prevVec(prevVec)
  );

endmodule

// File: rtl/pinirq_checker.sv
module pinirq_checker #(
  parameter int NUM_PINS = 8,
  parameter int REG_W    = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          regSel,
  input logic                wrEn,
  input logic [REG_W-1:0]    wrData,
  input logic [REG_W-1:0]    rdData,
  input logic                irqOut,
  input logic [NUM_PINS-1:0] syncVec,
  input logic [NUM_PINS-1:0] prevVec,
  input logic [NUM_PINS-1:0] polVec,
  input logic [NUM_PINS-1:0] enVec,
  input logic [NUM_PINS-1:0] flagVec
);

  localparam logic [REG_W-1:0] LOW_MASK = REG_W'({NUM_PINS{1'b1}});

  logic [NUM_PINS-1:0] clrMask, activeEdge;
  assign clrMask    = (wrEn && regSel == 2'd2) ? wrData[NUM_PINS-1:0] : '0;
  assign activeEdge = (syncVec ^ prevVec) & ~(syncVec ^ polVec);

  // R8: request is the registered OR of flag AND enable
  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(|(flagVec & enVec)));

  // R5: a set flag survives unless a write-1 clear hit it
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flagVec & $past(flagVec & ~clrMask)) == $past(flagVec & ~clrMask));

  // R4 / R6: an active synchronised edge always leaves the flag set, clear or not
  assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flagVec & $past(activeEdge)) == $past(activeEdge));

  // R7: a flag only rises after a real change of the synchronised sample
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flagVec & ~$past(flagVec) & ~$past(syncVec ^ prevVec)) == '0);

  // R2: enable write loads the low data bits
  assert_enable_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 2'd0) |=> enVec == $past(wrData[NUM_PINS-1:0]));

  // R9: bits above the implemented pins always read zero
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~LOW_MASK) == '0);

endmodule

bind pinirq_top pinirq_checker #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .irqOut(irqOut), .syncVec(syncVec), .prevVec(prevVec),
  .polVec(polVec), .enVec(enVec), .flagVec(flagVec)
);

// File: tb/pinirq_top_tb.sv
module pinirq_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pins = '0;
  logic [3:0] pinsN = '0;
  logic [1:0] regSel = 2'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, rdDataN;
  logic       irq, irqN;
  int         checks = 0;
  int         fails = 0;

  always #5 clk = ~clk;

  pinirq_top #(.NUM_PINS(8), .REG_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pins), .regSel(regSel), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irqOut(irq)
  );

  pinirq_top #(.NUM_PINS(4), .REG_W(8)) u_narrow (
    .clk(clk), .rstN(rstN), .pinIn(pinsN), .regSel(regSel), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdDataN), .irqOut(irqN)
  );

  // {startPins, endPins, polarity, enable, expectedFlags, expectedIrq}
  localparam logic [40:0] VEC [7] = '{
    {8'h00, 8'hFF, 8'hFF, 8'h01, 8'hFF, 1'b1},
    {8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00, 1'b0},
    {8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b0},
    {8'h0F, 8'hF0, 8'hF0, 8'h80, 8'hFF, 1'b1},
    {8'h0F, 8'hF0, 8'h0F, 8'hFF, 8'h00, 1'b0},
    {8'hA5, 8'h5A, 8'h55, 8'h0F, 8'hF0, 1'b0},
    {8'h3C, 8'h3C, 8'hC3, 8'hFF, 8'h00, 1'b0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    regSel = sel; wrData = data; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] data);
    regSel = sel;
    #1 data = rdData;
  endtask

  task automatic rdN(input logic [1:0] sel, output logic [7:0] data);
    regSel = sel;
    #1 data = rdDataN;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [40:0] v;
    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(2'd0, r); check("R1 enable", r, 8'h00);
    rd(2'd1, r); check("R1 polarity", r, 8'h00);
    rd(2'd2, r); check("R1 flags", r, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2: register access, select 3 inert
    wr(2'd0, 8'h96); rd(2'd0, r); check("R2 enable readback", r, 8'h96);
    wr(2'd1, 8'h3C); rd(2'd1, r); check("R2 polarity readback", r, 8'h3C);
    wr(2'd3, 8'hFF); rd(2'd3, r); check("R2 select3 reads 0", r, 8'h00);
    rd(2'd0, r); check("R2 select3 write ignored enable", r, 8'h96);
    rd(2'd1, r); check("R2 select3 write ignored polarity", r, 8'h3C);

    // R3 R4 R8: vector table
    for (int i = 0; i < 7; i++) begin
      v = VEC[i];
      pins = v[40:33];
      waitCycles(4);
      wr(2'd1, v[24:17]);
      wr(2'd0, v[16:9]);
      wr(2'd2, 8'hFF);
      pins = v[32:25];
      waitCycles(5);
      rd(2'd2, r); check($sformatf("R3 R4 vector %0d flags", i), r, v[8:1]);
      check($sformatf("R8 vector %0d irq", i), {7'd0, irq}, {7'd0, v[0]});
    end

    // R8: exact latency and masking
    pins = 8'h00; waitCycles(4);
    wr(2'd1, 8'h01); wr(2'd0, 8'h01); wr(2'd2, 8'hFF);
    pins = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(2'd2, r); check("R4 flag after third edge", r, 8'h01);
    check("R8 irq not yet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R8 irq one cycle later", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h00);
    @(negedge clk);
    check("R8 irq masked by enable", {7'd0, irq}, 8'h00);

    // R5: write 0 keeps, write 1 clears
    pins = 8'h0F; wr(2'd1, 8'hFF); waitCycles(5);
    rd(2'd2, r); check("R5 setup flags", r, 8'h0F);
    wr(2'd2, 8'h00); rd(2'd2, r); check("R5 write zero keeps", r, 8'h0F);
    wr(2'd2, 8'h05); rd(2'd2, r); check("R5 write one clears", r, 8'h0A);
    wr(2'd2, 8'hFF); rd(2'd2, r); check("R5 clear all", r, 8'h00);

    // R6: set wins over simultaneous clear
    pins = 8'h00; waitCycles(5);
    pins = 8'h01;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    regSel = 2'd2; wrData = 8'h01; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    rd(2'd2, r); check("R6 set wins", r, 8'h01);
    wr(2'd2, 8'hFF);

    // R7: polarity toggle on steady pins
    pins = 8'hF0; waitCycles(5); wr(2'd2, 8'hFF);
    wr(2'd1, 8'h00); waitCycles(2);
    wr(2'd1, 8'hFF); waitCycles(2);
    wr(2'd1, 8'h0F); waitCycles(4);
    rd(2'd2, r); check("R7 polarity toggle no flag", r, 8'h00);

    // R9: narrow instance upper bits
    wr(2'd0, 8'hFF); rdN(2'd0, r); check("R9 narrow enable", r, 8'h0F);
    wr(2'd1, 8'hFF); rdN(2'd1, r); check("R9 narrow polarity", r, 8'h0F);
    pinsN = 4'hF; waitCycles(5);
    rdN(2'd2, r); check("R9 narrow flags", r, 8'h0F);
    check("R9 narrow irq", {7'd0, irqN}, 8'h01);
    wr(2'd2, 8'hF0); rdN(2'd2, r); check("R9 upper clear ignored", r, 8'h0F);
    wr(2'd2, 8'h0F); rdN(2'd2, r); check("R9 narrow clear", r, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule